// File: doc/BRIEF.md
# Host / Sound-Coprocessor Command and Data Mailbox

This block passes bytes both ways between a host processor bus and a sound coprocessor bus that run on one shared clock. Each bus reaches the block through strobes that its own address decoder has already produced, together with an 8-bit write byte. Three byte registers carry the traffic: a command byte and a data byte going from the host to the coprocessor, and a data byte going back from the coprocessor to the host.

Two handshake flags tell each side when the other one has acted. The command flag and the data flag appear in one status byte that both buses can read. Certain accesses raise or drop a flag as a side effect. These include a port whose only job is to drop the command flag, and two compatibility ports that load a flag from a bit of a register kept elsewhere. When a raise and a drop reach the same flag in the same cycle, a fixed priority decides the result.

The host also writes a control byte. Each of its bits starts an action on the coprocessor: a reset held for a set number of cycles, a single-cycle interrupt pulse, or a toggle of the indicator lamp.

Top module: `hostcop_mailbox`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, both flags read 0, the three byte registers read 0x00, `cop_rst` and `cop_nmi` are 0, and `led_on` is 1.
- R2: A cycle with `h_cmd_we` high stores `h_wdata` into the command register, which shows on `c_cmd` in the next cycle. The same write sets the command flag, which is status bit 0.
- R3: A cycle with `h_dat_we` high stores `h_wdata` into the host-to-coprocessor data register, which shows on `c_rdata` in the next cycle. The same write sets the data flag, which is status bit 7.
- R4: A cycle with `c_dat_we` high stores `c_wdata` into the coprocessor-to-host data register, which shows on `h_rdata` in the next cycle. The same write sets the data flag.
- R5: A cycle with `c_dat_rd` high clears the data flag in the next cycle. The data register it reads is left unchanged.
- R6: A cycle with `c_clr_acc` high clears the command flag in the next cycle.
- R7: A cycle with `c_leg_dat_acc` high loads the data flag with the inverse of `c_page_lsb`. A cycle with `c_leg_cmd_acc` high loads the command flag with `c_vol4_b5`.
- R8: When several events reach one flag in the same cycle, a set from a write wins over a legacy load, and a legacy load wins over a clear.
- R9: `h_status` and `c_status` are always equal. Bit 0 is the command flag, bit 7 is the data flag, and bits 1 to 6 read 0.
- R10: A control write (`h_ctl_we`) with bit 6 of `h_wdata` set drives `cop_nmi` high for exactly the next cycle.
- R11: A control write with bit 7 set drives `cop_rst` high for the next 4 cycles. A further such write while `cop_rst` is high starts the 4-cycle count again.
- R12: A control write with bit 5 set inverts `led_on` in the next cycle. The three control bits act independently within one byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both buses |
| rst_n | input | 1 | Active-low synchronous reset |
| h_cmd_we | input | 1 | Host writes the command register |
| h_dat_we | input | 1 | Host writes the host-to-coprocessor data register |
| h_ctl_we | input | 1 | Host writes the control byte |
| h_wdata | input | 8 | Host write byte |
| h_status | output | 8 | Status byte seen by the host |
| h_rdata | output | 8 | Coprocessor-to-host data register |
| c_dat_rd | input | 1 | Coprocessor reads host data (clears the data flag) |
| c_dat_we | input | 1 | Coprocessor writes coprocessor-to-host data |
| c_clr_acc | input | 1 | Access to the command-clear port |
| c_leg_dat_acc | input | 1 | Access to the legacy data-flag port |
| c_leg_cmd_acc | input | 1 | Access to the legacy command-flag port |
| c_wdata | input | 8 | Coprocessor write byte |
| c_page_lsb | input | 1 | Bit 0 of the memory page register |
| c_vol4_b5 | input | 1 | Bit 5 of the channel-4 volume register |
| c_cmd | output | 8 | Command register seen by the coprocessor |
| c_rdata | output | 8 | Host-to-coprocessor data register |
| c_status | output | 8 | Status byte seen by the coprocessor |
| cop_rst | output | 1 | Coprocessor reset, held for 4 cycles |
| cop_nmi | output | 1 | Coprocessor interrupt pulse |
| led_on | output | 1 | Indicator lamp, 1 = lit |

## Verification
The hardest timing cases are a flag being set by one bus and dropped by the other in the same cycle. Examples are a host data write in the cycle of a coprocessor data read, and a host command write in the cycle of an access to the clear port or the legacy command port. Directed cycles force each of these pairings, and a random phase with dense, independent strobes creates more of them. A behavioural model applies the set-over-load-over-clear rule, and every cycle the flag bits of both status bytes are compared with it.

// File: rtl/mb_pkg.sv
package mb_pkg;
   // Events that can reach one handshake flag in one cycle
   typedef struct packed {
      logic set;       // write-side set
      logic load;      // legacy load
      logic load_val;  // value for legacy load
      logic clr;       // clear
   } flag_evt_t;
endpackage

// File: rtl/mb_flag.sv
module mb_flag
   import mb_pkg::*;
#(
   parameter bit SET_WINS = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  flag_evt_t evt,
   output logic      q
);
   logic nxt;

   generate
      if (SET_WINS) begin : g_set_first
         always_comb begin
            if (evt.set)       nxt = 1'b1;
            else if (evt.load) nxt = evt.load_val;
            else if (evt.clr)  nxt = 1'b0;
            else               nxt = q;
         end
      end else begin : g_clr_first
         always_comb begin
            if (evt.clr)       nxt = 1'b0;
            else if (evt.load) nxt = evt.load_val;
            else if (evt.set)  nxt = 1'b1;
            else               nxt = q;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) q <= 1'b0;
      else        q <= nxt;
   end
endmodule

// File: rtl/mb_byte_reg.sv
module mb_byte_reg #(
   parameter int          DW      = 8,
   parameter logic [DW-1:0] RST_VAL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [DW-1:0] d,
   output logic [DW-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)  q <= RST_VAL;
      else if (we) q <= d;
   end
endmodule

// File: rtl/mb_ctl.sv
module mb_ctl #(
   parameter int DW         = 8,
   parameter int RST_BIT    = 7,
   parameter int NMI_BIT    = 6,
   parameter int LED_BIT    = 5,
   parameter int RST_CYCLES = 4,
   parameter bit LED_RST    = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [DW-1:0] d,
   output logic          cop_rst,
   output logic          cop_nmi,
   output logic          led_on
);
   localparam int CW = $clog2(RST_CYCLES + 1);

   initial begin
      assert (RST_CYCLES >= 1) else $fatal(1, "mb_ctl: RST_CYCLES must be at least 1");
      assert (RST_BIT < DW && NMI_BIT < DW && LED_BIT < DW)
         else $fatal(1, "mb_ctl: control bit outside the byte");
   end

   logic rst_req, nmi_req, led_req;
   assign rst_req = we & d[RST_BIT];
   assign nmi_req = we & d[NMI_BIT];
   assign led_req = we & d[LED_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cop_nmi <= 1'b0;
         led_on  <= LED_RST;
      end else begin
         cop_nmi <= nmi_req;
         if (led_req) led_on <= ~led_on;
      end
   end

   generate
      if (RST_CYCLES == 1) begin : g_rst_single
         logic rst_q;
         always_ff @(posedge clk) begin
            if (!rst_n) rst_q <= 1'b0;
            else        rst_q <= rst_req;
         end
         assign cop_rst = rst_q;
      end else begin : g_rst_count
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n)             cnt <= '0;
            else if (rst_req)       cnt <= CW'(RST_CYCLES);
            else if (cnt != '0)     cnt <= cnt - 1'b1;
         end
         assign cop_rst = (cnt != '0);
      end
   endgenerate
endmodule

// File: rtl/hostcop_mailbox.sv
module hostcop_mailbox
   import mb_pkg::*;
#(
   parameter int DW           = 8,
   parameter int CMD_FLAG_BIT = 0,
   parameter int DAT_FLAG_BIT = 7,
   parameter int RST_BIT      = 7,
   parameter int NMI_BIT      = 6,
   parameter int LED_BIT      = 5,
   parameter int RST_CYCLES   = 4,
   parameter bit SET_WINS     = 1'b1,
   parameter bit LED_RST      = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          h_cmd_we,
   input  logic          h_dat_we,
   input  logic          h_ctl_we,
   input  logic [DW-1:0] h_wdata,
   output logic [DW-1:0] h_status,
   output logic [DW-1:0] h_rdata,
   input  logic          c_dat_rd,
   input  logic          c_dat_we,
   input  logic          c_clr_acc,
   input  logic          c_leg_dat_acc,
   input  logic          c_leg_cmd_acc,
   input  logic [DW-1:0] c_wdata,
   input  logic          c_page_lsb,
   input  logic          c_vol4_b5,
   output logic [DW-1:0] c_cmd,
   output logic [DW-1:0] c_rdata,
   output logic [DW-1:0] c_status,
   output logic          cop_rst,
   output logic          cop_nmi,
   output logic          led_on
);
   initial begin
      assert (CMD_FLAG_BIT != DAT_FLAG_BIT)
         else $fatal(1, "hostcop_mailbox: flag positions collide");
      assert (CMD_FLAG_BIT < DW && DAT_FLAG_BIT < DW)
         else $fatal(1, "hostcop_mailbox: flag position outside the byte");
   end

   // ---------------- byte registers ----------------
   mb_byte_reg #(.DW(DW)) u_cmd_reg (
      .clk(clk), .rst_n(rst_n), .we(h_cmd_we), .d(h_wdata), .q(c_cmd)
   );
   mb_byte_reg #(.DW(DW)) u_h2c_reg (
      .clk(clk), .rst_n(rst_n), .we(h_dat_we), .d(h_wdata), .q(c_rdata)
   );
   mb_byte_reg #(.DW(DW)) u_c2h_reg (
      .clk(clk), .rst_n(rst_n), .we(c_dat_we), .d(c_wdata), .q(h_rdata)
   );

   // ---------------- handshake flags ----------------
   flag_evt_t cmd_evt, dat_evt;
   logic      cmd_flag, dat_flag;

   always_comb begin
      cmd_evt.set      = h_cmd_we;
      cmd_evt.load     = c_leg_cmd_acc;
      cmd_evt.load_val = c_vol4_b5;
      cmd_evt.clr      = c_clr_acc;
      dat_evt.set      = h_dat_we | c_dat_we;
      dat_evt.load     = c_leg_dat_acc;
      dat_evt.load_val = ~c_page_lsb;
      dat_evt.clr      = c_dat_rd;
   end

   mb_flag #(.SET_WINS(SET_WINS)) u_cmd_flag (
      .clk(clk), .rst_n(rst_n), .evt(cmd_evt), .q(cmd_flag)
   );
   mb_flag #(.SET_WINS(SET_WINS)) u_dat_flag (
      .clk(clk), .rst_n(rst_n), .evt(dat_evt), .q(dat_flag)
   );

   // ---------------- status byte ----------------
   logic [DW-1:0] status;
   generate
      for (genvar b = 0; b < DW; b++) begin : g_stat
         if (b == CMD_FLAG_BIT) begin : g_cmd
            assign status[b] = cmd_flag;
         end else if (b == DAT_FLAG_BIT) begin : g_dat
            assign status[b] = dat_flag;
         end else begin : g_zero
            assign status[b] = 1'b0;
         end
      end
   endgenerate

   assign h_status = status;
   assign c_status = status;

   // ---------------- host control byte ----------------
   mb_ctl #(
      .DW(DW), .RST_BIT(RST_BIT), .NMI_BIT(NMI_BIT), .LED_BIT(LED_BIT),
      .RST_CYCLES(RST_CYCLES), .LED_RST(LED_RST)
   ) u_ctl (
      .clk(clk), .rst_n(rst_n), .we(h_ctl_we), .d(h_wdata),
      .cop_rst(cop_rst), .cop_nmi(cop_nmi), .led_on(led_on)
   );
endmodule

// File: rtl/mb_checker.sv
module mb_checker #(
   parameter int DW           = 8,
   parameter int CMD_FLAG_BIT = 0,
   parameter int DAT_FLAG_BIT = 7,
   parameter int RST_BIT      = 7,
   parameter int NMI_BIT      = 6,
   parameter int LED_BIT      = 5,
   parameter int RST_CYCLES   = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          h_cmd_we,
   input logic          h_dat_we,
   input logic          h_ctl_we,
   input logic [DW-1:0] h_wdata,
   input logic [DW-1:0] h_status,
   input logic [DW-1:0] c_status,
   input logic [DW-1:0] c_cmd,
   input logic          c_dat_rd,
   input logic          c_dat_we,
   input logic          c_clr_acc,
   input logic          c_leg_dat_acc,
   input logic          c_leg_cmd_acc,
   input logic          cop_rst,
   input logic          cop_nmi,
   input logic          led_on
);
   localparam int HW = $clog2(RST_CYCLES + 2);

   // length of the current cop_rst window, counted here independently
   logic [HW-1:0] hi_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n)                              hi_cnt <= '0;
      else if (h_ctl_we && h_wdata[RST_BIT])   hi_cnt <= HW'(1);
      else if (cop_rst && hi_cnt <= HW'(RST_CYCLES)) hi_cnt <= hi_cnt + 1'b1;
      else if (!cop_rst)                       hi_cnt <= '0;
   end

   AST_CMD_WR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      h_cmd_we |=> h_status[CMD_FLAG_BIT]);                                  // R2
   AST_CMD_WR_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      h_cmd_we |=> c_cmd == $past(h_wdata));                                 // R2
   AST_DAT_WR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (h_dat_we || c_dat_we) |=> h_status[DAT_FLAG_BIT]);                    // R3
   AST_DAT_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (c_dat_rd && !h_dat_we && !c_dat_we && !c_leg_dat_acc)
         |=> !h_status[DAT_FLAG_BIT]);                                       // R5
   AST_CLR_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      (c_clr_acc && !h_cmd_we && !c_leg_cmd_acc) |=> !h_status[CMD_FLAG_BIT]); // R6
   AST_SET_OVER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (h_cmd_we && c_clr_acc) |=> h_status[CMD_FLAG_BIT]);                   // R8
   AST_STATUS_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
      h_status == c_status);                                                 // R9
   AST_NMI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      cop_nmi |-> $past(h_ctl_we && h_wdata[NMI_BIT]));                      // R10
   AST_NMI_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (h_ctl_we && h_wdata[NMI_BIT]) |=> cop_nmi);                           // R10
   AST_RST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cop_rst |-> (hi_cnt >= HW'(1) && hi_cnt <= HW'(RST_CYCLES)));          // R11
   AST_RST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_cnt >= HW'(1) && hi_cnt <= HW'(RST_CYCLES)) |-> cop_rst);          // R11
   AST_LED_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(led_on) |-> $past(h_ctl_we && h_wdata[LED_BIT]));             // R12
endmodule

bind hostcop_mailbox mb_checker #(
   .DW(DW), .CMD_FLAG_BIT(CMD_FLAG_BIT), .DAT_FLAG_BIT(DAT_FLAG_BIT),
   .RST_BIT(RST_BIT), .NMI_BIT(NMI_BIT), .LED_BIT(LED_BIT), .RST_CYCLES(RST_CYCLES)
) u_mb_checker (
   .clk(clk), .rst_n(rst_n), .h_cmd_we(h_cmd_we), .h_dat_we(h_dat_we),
   .h_ctl_we(h_ctl_we), .h_wdata(h_wdata), .h_status(h_status), .c_status(c_status),
   .c_cmd(c_cmd), .c_dat_rd(c_dat_rd), .c_dat_we(c_dat_we), .c_clr_acc(c_clr_acc),
   .c_leg_dat_acc(c_leg_dat_acc), .c_leg_cmd_acc(c_leg_cmd_acc),
   .cop_rst(cop_rst), .cop_nmi(cop_nmi), .led_on(led_on)
);

// File: tb/test_hostcop_mailbox.sv
`timescale 1ns/1ps
module test_hostcop_mailbox;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       h_cmd_we, h_dat_we, h_ctl_we;
   logic [7:0] h_wdata;
   logic [7:0] h_status, h_rdata;
   logic       c_dat_rd, c_dat_we, c_clr_acc, c_leg_dat_acc, c_leg_cmd_acc;
   logic [7:0] c_wdata;
   logic       c_page_lsb, c_vol4_b5;
   logic [7:0] c_cmd, c_rdata, c_status;
   logic       cop_rst, cop_nmi, led_on;

   always #10 clk = ~clk;  // 50 MHz

   hostcop_mailbox i_hostcop_mailbox (
      .clk(clk), .rst_n(rst_n),
      .h_cmd_we(h_cmd_we), .h_dat_we(h_dat_we), .h_ctl_we(h_ctl_we), .h_wdata(h_wdata),
      .h_status(h_status), .h_rdata(h_rdata),
      .c_dat_rd(c_dat_rd), .c_dat_we(c_dat_we), .c_clr_acc(c_clr_acc),
      .c_leg_dat_acc(c_leg_dat_acc), .c_leg_cmd_acc(c_leg_cmd_acc), .c_wdata(c_wdata),
      .c_page_lsb(c_page_lsb), .c_vol4_b5(c_vol4_b5),
      .c_cmd(c_cmd), .c_rdata(c_rdata), .c_status(c_status),
      .cop_rst(cop_rst), .cop_nmi(cop_nmi), .led_on(led_on)
   );

   int checks = 0;
   int failures = 0;
   bit done = 0;
   bit compare_on = 0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_cmdf, m_datf, m_cmd, m_h2c, m_c2h, m_nmi, m_led, m_rst_left;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cmdf = 0; m_datf = 0; m_cmd = 0; m_h2c = 0; m_c2h = 0;
         m_nmi = 0; m_led = 1; m_rst_left = 0;
      end else begin
         // command flag: write set, then legacy load, then clear
         if (h_cmd_we)           m_cmdf = 1;
         else if (c_leg_cmd_acc) m_cmdf = c_vol4_b5 ? 1 : 0;
         else if (c_clr_acc)     m_cmdf = 0;
         // data flag: same ordering
         if (h_dat_we || c_dat_we) m_datf = 1;
         else if (c_leg_dat_acc)   m_datf = c_page_lsb ? 0 : 1;
         else if (c_dat_rd)        m_datf = 0;
         if (h_cmd_we) m_cmd = h_wdata;
         if (h_dat_we) m_h2c = h_wdata;
         if (c_dat_we) m_c2h = c_wdata;
         m_nmi = (h_ctl_we && h_wdata[6]) ? 1 : 0;
         if (h_ctl_we && h_wdata[5]) m_led = 1 - m_led;
         if (h_ctl_we && h_wdata[7]) m_rst_left = 4;
         else if (m_rst_left > 0)    m_rst_left = m_rst_left - 1;
      end
   end

   // every-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (compare_on && !done) begin
         int exp_stat;
         exp_stat = (m_datf << 7) | m_cmdf;
         check(h_status[0] == m_cmdf[0], "R2 R6 R7 R8 command flag", h_status[0], m_cmdf);
         check(h_status[7] == m_datf[0], "R3 R4 R5 R7 R8 data flag", h_status[7], m_datf);
         check(h_status == exp_stat[7:0] && c_status == exp_stat[7:0],
               "R9 status byte", {h_status, c_status}, {exp_stat[7:0], exp_stat[7:0]});
         check(c_cmd == m_cmd[7:0], "R2 command byte", c_cmd, m_cmd);
         check(c_rdata == m_h2c[7:0], "R3 host data byte", c_rdata, m_h2c);
         check(h_rdata == m_c2h[7:0], "R4 coprocessor data byte", h_rdata, m_c2h);
         check(cop_nmi == m_nmi[0], "R10 nmi pulse", cop_nmi, m_nmi);
         check(cop_rst == (m_rst_left > 0), "R11 reset window", cop_rst, (m_rst_left > 0));
         check(led_on == m_led[0], "R12 lamp", led_on, m_led);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic idle();
      h_cmd_we = 0; h_dat_we = 0; h_ctl_we = 0;
      c_dat_rd = 0; c_dat_we = 0; c_clr_acc = 0; c_leg_dat_acc = 0; c_leg_cmd_acc = 0;
   endtask

   task automatic step();  // let one edge capture the inputs, land at posedge+5
      @(posedge clk);
      #5;
   endtask

   logic [31:0] lcg = 32'h1234_5678;
   function automatic logic [31:0] nxt(input logic [31:0] s);
      return s * 32'd1664525 + 32'd1013904223;
   endfunction

   // watchdog
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         failures++;
         $display("FAIL watchdog all requirements actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      idle();
      h_wdata = 0; c_wdata = 0; c_page_lsb = 0; c_vol4_b5 = 0;
      rst_n = 0;
      repeat (3) step();
      // R1: reset values while reset is held
      #5;
      check(h_status == 8'h00 && c_status == 8'h00, "R1 status in reset", h_status, 0);
      check(c_cmd == 0 && c_rdata == 0 && h_rdata == 0, "R1 registers in reset",
            {c_cmd, c_rdata, h_rdata}, 0);
      check(!cop_rst && !cop_nmi && led_on, "R1 control outputs in reset",
            {cop_rst, cop_nmi, led_on}, 3'b001);
      #5;
      rst_n = 1;
      compare_on = 1;
      step();

      // R2 + R6 + R8: host command write together with clear port
      h_cmd_we = 1; h_wdata = 8'hA5; c_clr_acc = 1;
      step(); idle(); #5;
      check(h_status[0] == 1'b1, "R8 set beats clear on command flag", h_status[0], 1);
      check(c_cmd == 8'hA5, "R2 command byte stored", c_cmd, 8'hA5);
      step();
      c_clr_acc = 1; step(); idle(); #5;
      check(h_status[0] == 1'b0, "R6 clear port drops command flag", h_status[0], 0);
      step();

      // R3 + R5 + R8: host data write during coprocessor data read
      h_dat_we = 1; h_wdata = 8'h3C; c_dat_rd = 1;
      step(); idle(); #5;
      check(h_status[7] == 1'b1, "R8 set beats read-clear on data flag", h_status[7], 1);
      check(c_rdata == 8'h3C, "R3 data byte stored", c_rdata, 8'h3C);
      step();
      c_dat_rd = 1; step(); idle(); #5;
      check(h_status[7] == 1'b0 && c_rdata == 8'h3C, "R5 read clears flag, keeps byte",
            {h_status[7], c_rdata}, {1'b0, 8'h3C});
      step();

      // R4: coprocessor data write
      c_dat_we = 1; c_wdata = 8'hC3; step(); idle(); #5;
      check(h_rdata == 8'hC3 && c_status[7], "R4 coprocessor data and flag",
            {h_rdata, c_status[7]}, {8'hC3, 1'b1});
      step();

      // R7: legacy loads, and R8 load beats clear
      c_page_lsb = 1; c_leg_dat_acc = 1; c_dat_rd = 1;
      c_vol4_b5 = 1; c_leg_cmd_acc = 1; c_clr_acc = 1;
      step(); idle(); #5;
      check(h_status == 8'h01, "R7 R8 legacy loads over clears", h_status, 8'h01);
      step();
      c_page_lsb = 0; c_leg_dat_acc = 1; c_vol4_b5 = 0; c_leg_cmd_acc = 1;
      step(); idle(); #5;
      check(h_status == 8'h80, "R7 legacy loads opposite values", h_status, 8'h80);
      step();
      // R8: write set beats legacy load
      h_cmd_we = 1; h_wdata = 8'h11; c_vol4_b5 = 0; c_leg_cmd_acc = 1;
      step(); idle(); #5;
      check(h_status[0] == 1'b1, "R8 write set beats legacy load", h_status[0], 1);
      step();

      // R10 R11 R12: all three control bits in one byte
      h_ctl_we = 1; h_wdata = 8'hE0; step(); idle(); #5;
      check(cop_nmi && cop_rst && !led_on, "R10 R11 R12 control byte 0xE0",
            {cop_nmi, cop_rst, led_on}, 3'b110);
      step(); #5;
      check(!cop_nmi, "R10 nmi lasts one cycle", cop_nmi, 0);
      step(); step(); #5;
      check(cop_rst, "R11 reset still held in 4th cycle", cop_rst, 1);
      step(); #5;
      check(!cop_rst, "R11 reset released after 4 cycles", cop_rst, 0);
      step();
      // R11 restart
      h_ctl_we = 1; h_wdata = 8'h80; step(); idle();
      step(); step();
      h_ctl_we = 1; h_wdata = 8'h80; step(); idle();
      repeat (3) step();
      #5;
      check(cop_rst, "R11 restarted window still high", cop_rst, 1);
      step();
      // R12 lamp toggles back
      h_ctl_we = 1; h_wdata = 8'h20; step(); idle(); #5;
      check(led_on, "R12 lamp toggled back on", led_on, 1);
      step();

      // random phase with dense independent strobes
      for (int i = 0; i < 4000; i++) begin
         lcg = nxt(lcg);
         h_cmd_we      = (lcg[2:0] == 3'd0);
         h_dat_we      = (lcg[5:3] == 3'd0);
         h_ctl_we      = (lcg[9:6] == 4'd0);
         c_dat_rd      = (lcg[12:10] == 3'd0);
         c_dat_we      = (lcg[15:13] == 3'd0);
         c_clr_acc     = (lcg[18:16] == 3'd0);
         c_leg_dat_acc = (lcg[22:19] == 4'd0);
         c_leg_cmd_acc = (lcg[26:23] == 4'd0);
         c_page_lsb    = lcg[27];
         c_vol4_b5     = lcg[28];
         lcg = nxt(lcg);
         h_wdata = lcg[7:0];
         c_wdata = lcg[15:8];
         step();
      end
      idle();
      step(); step();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule